// File: doc/BRIEF.md
# Transmit DMA Channel with Byte Unpacker

This block moves a buffer from memory to a byte-wide transmit peripheral. Software fills one of two descriptor slots, each holding a start address and a byte count. The channel then fetches 32-bit words one at a time. Each word goes into a single-word unpacker, which hands out bytes in little-endian order over a valid/ready handshake. A new word is fetched only after the unpacker has handed out its last useful byte. The first word of an unaligned buffer supplies only the bytes from the start offset onward. The last word supplies only as many bytes as the count still allows.

A buffer ends in one of two ways. When the count runs out, the channel raises a terminal-count flag alongside the final byte. When the peripheral raises its end-of-stream input on a handshake, that byte is the last one, and any bytes still held in the unpacker are discarded unsent. At either end the channel records the cause and the number of bytes sent, pulses an interrupt, retires the slot it used and points to the other slot. If that slot has not been loaded, the channel holds off the peripheral until software writes it.

Top module: `txdma_chan`

## Requirements
- R1: After reset the outputs are quiet: rd_req, tx_valid, tx_tc and irq are 0, and nxt_buf, stat_cnt, stat_tc and stat_eos are 0.
- R2: The channel issues a memory read only while the unpacker is empty, never while tx_valid is 1. Each buffer costs exactly one read per 32-bit word that holds at least one of its delivered bytes.
- R3: Read addresses are word aligned (rd_addr[1:0] = 0). rd_req and rd_addr stay steady until rd_ack. The byte at address A sits in rd_data bits [8*A[1:0]+7 : 8*A[1:0]].
- R4: Delivered bytes follow memory order starting at the slot's base, including a base with a nonzero offset within a word.
- R5: tx_tc is 1 exactly while the byte on tx_data is the last one the count allows. When that byte is accepted, the buffer ends with stat_tc = 1.
- R6: A handshake with tx_end = 1 makes that byte the last one. The unsent bytes of the buffer are dropped, stat_eos becomes 1, and stat_cnt gives the number of bytes accepted.
- R7: At a buffer end irq is high for exactly one cycle. In that same cycle, the status fields hold the new values and nxt_buf has flipped. Slots are used in the order 0, 1, 0, 1...
- R8: While the selected slot holds no valid descriptor, tx_valid and rd_req stay 0.
- R9: A descriptor write with a zero count is ignored. A write to the slot in use while a buffer is being sent is also ignored.
- R10: Each buffer starts with a fresh read at its own base. No unpacker data carries over from the previous buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Descriptor write strobe |
| cfg_sel | input | 1 | Slot written (0 or 1) |
| cfg_base | input | AW | Buffer start byte address |
| cfg_cnt | input | CW | Buffer byte count |
| rd_req | output | 1 | Memory word read request |
| rd_addr | output | AW | Word-aligned read address |
| rd_ack | input | 1 | Read data valid, completes the request |
| rd_data | input | 32 | Read word |
| tx_valid | output | 1 | Byte offered to the peripheral |
| tx_data | output | 8 | Byte value |
| tx_ready | input | 1 | Peripheral accepts the byte |
| tx_end | input | 1 | Accepted byte is the last of the stream |
| tx_tc | output | 1 | Offered byte is the last the count allows |
| irq | output | 1 | One-cycle buffer-end pulse |
| nxt_buf | output | 1 | Slot to be used next |
| stat_cnt | output | CW | Bytes accepted in the finished buffer |
| stat_tc | output | 1 | Finished buffer ended on count |
| stat_eos | output | 1 | Finished buffer ended on peripheral end-of-stream |

## Verification
The count limit and the peripheral's end-of-stream can land on the same accepted byte. In that case both status flags must be set, and stat_cnt must still equal the full count. The sweep covers every end position from the first byte through the last, for every count from 1 to 9 and every start offset. Placing tx_end on the final byte makes the two end conditions coincide, and the bench predicts the status arithmetically: end-of-stream is set whenever tx_end was used, and terminal count is set whenever the number of bytes sent equals the count.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DRAIN = 2'd2
  } chan_st_e;

  localparam int LANES  = 4;
  localparam int NSLOTS = 2;
endpackage

// File: rtl/txdma_desc_bank.sv
module txdma_desc_bank #(
  parameter int AW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          wr_sel,
  input  logic [AW-1:0] wr_base,
  input  logic [CW-1:0] wr_cnt,
  input  logic          busy,
  input  logic          cur,
  input  logic          retire,
  output logic [AW-1:0] base_o,
  output logic [CW-1:0] cnt_o,
  output logic          vld_o
);
  import txdma_pkg::*;

  logic [AW-1:0]     base_q [NSLOTS];
  logic [AW-1:0]     base_d [NSLOTS];
  logic [CW-1:0]     cnt_q  [NSLOTS];
  logic [CW-1:0]     cnt_d  [NSLOTS];
  logic [NSLOTS-1:0] vld_q, vld_d;
  logic [NSLOTS-1:0] we, clr;

  for (genvar p = 0; p < NSLOTS; p++) begin : g_slot
    // a slot in use may not be rewritten; a zero count is never accepted
    assign we[p]  = wr && (wr_sel == 1'(p)) && (wr_cnt != '0)
                    && !(busy && (cur == 1'(p)));
    assign clr[p] = retire && (cur == 1'(p));
  end

  always_comb begin
    vld_d = vld_q;
    for (int p = 0; p < NSLOTS; p++) begin
      base_d[p] = base_q[p];
      cnt_d[p]  = cnt_q[p];
      if (we[p]) begin
        base_d[p] = wr_base;
        cnt_d[p]  = wr_cnt;
        vld_d[p]  = 1'b1;
      end else if (clr[p]) begin
        vld_d[p] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int p = 0; p < NSLOTS; p++) begin
        base_q[p] <= '0;
        cnt_q[p]  <= '0;
      end
    end else begin
      vld_q <= vld_d;
      for (int p = 0; p < NSLOTS; p++) begin
        base_q[p] <= base_d[p];
        cnt_q[p]  <= cnt_d[p];
      end
    end
  end

  assign base_o = base_q[cur];
  assign cnt_o  = cnt_q[cur];
  assign vld_o  = vld_q[cur];
endmodule

// File: rtl/txdma_unpacker.sv
module txdma_unpacker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld,
  input  logic [31:0] word_i,
  input  logic [1:0]  first_i,
  input  logic [2:0]  n_i,
  input  logic        adv,
  input  logic        flush,
  output logic [7:0]  byte_o,
  output logic        one_left,
  output logic        empty
);
  logic [31:0] word_q, word_d;
  logic [2:0]  bptr_q, bptr_d;
  logic [2:0]  bend_q, bend_d;

  always_comb begin
    word_d = word_q;
    bptr_d = bptr_q;
    bend_d = bend_q;
    if (ld) begin
      word_d = word_i;
      bptr_d = {1'b0, first_i};
      bend_d = {1'b0, first_i} + n_i;
    end else if (flush) begin
      bptr_d = bend_q;
    end else if (adv) begin
      bptr_d = bptr_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      bptr_q <= '0;
      bend_q <= '0;
    end else begin
      word_q <= word_d;
      bptr_q <= bptr_d;
      bend_q <= bend_d;
    end
  end

  assign byte_o   = word_q[8*bptr_q[1:0] +: 8];
  assign one_left = (bptr_q + 3'd1) == bend_q;
  assign empty    = bptr_q == bend_q;
endmodule

// File: rtl/txdma_ctrl.sv
module txdma_ctrl #(
  parameter int AW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          d_vld,
  input  logic [AW-1:0] d_base,
  input  logic [CW-1:0] d_cnt,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  output logic          ld,
  output logic [1:0]    ld_first,
  output logic [2:0]    ld_n,
  input  logic          u_one_left,
  output logic          adv,
  output logic          flush,
  output logic          tx_valid,
  input  logic          tx_ready,
  input  logic          tx_end,
  output logic          tx_tc,
  output logic          busy,
  output logic          cur,
  output logic          retire,
  output logic          irq,
  output logic [CW-1:0] stat_cnt,
  output logic          stat_tc,
  output logic          stat_eos
);
  import txdma_pkg::*;

  chan_st_e      state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] rem_q, rem_d;
  logic [CW-1:0] sent_q, sent_d;
  logic          cur_q, cur_d;
  logic          irq_q, irq_d;
  logic [CW-1:0] scnt_q, scnt_d;
  logic          stc_q, stc_d;
  logic          seos_q, seos_d;
  logic          last_cnt;
  logic [2:0]    room;

  assign last_cnt = rem_q == CW'(1);
  assign room     = 3'd4 - {1'b0, addr_q[1:0]};

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    sent_d  = sent_q;
    cur_d   = cur_q;
    irq_d   = 1'b0;
    scnt_d  = scnt_q;
    stc_d   = stc_q;
    seos_d  = seos_q;
    ld      = 1'b0;
    adv     = 1'b0;
    flush   = 1'b0;
    retire  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (d_vld) begin
          addr_d  = d_base;
          rem_d   = d_cnt;
          sent_d  = '0;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (rd_ack) begin
          ld      = 1'b1;
          state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (tx_ready) begin
          adv    = 1'b1;
          addr_d = addr_q + AW'(1);
          rem_d  = rem_q - CW'(1);
          sent_d = sent_q + CW'(1);
          if (last_cnt || tx_end) begin
            flush   = 1'b1;
            retire  = 1'b1;
            irq_d   = 1'b1;
            cur_d   = ~cur_q;
            scnt_d  = sent_q + CW'(1);
            stc_d   = last_cnt;
            seos_d  = tx_end;
            state_d = ST_IDLE;
          end else if (u_one_left) begin
            state_d = ST_FETCH;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      sent_q  <= '0;
      cur_q   <= 1'b0;
      irq_q   <= 1'b0;
      scnt_q  <= '0;
      stc_q   <= 1'b0;
      seos_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      sent_q  <= sent_d;
      cur_q   <= cur_d;
      irq_q   <= irq_d;
      scnt_q  <= scnt_d;
      stc_q   <= stc_d;
      seos_q  <= seos_d;
    end
  end

  assign rd_req   = state_q == ST_FETCH;
  assign rd_addr  = {addr_q[AW-1:2], 2'b00};
  assign ld_first = addr_q[1:0];
  assign ld_n     = (rem_q < CW'(room)) ? rem_q[2:0] : room;
  assign tx_valid = state_q == ST_DRAIN;
  assign tx_tc    = (state_q == ST_DRAIN) && last_cnt;
  assign busy     = state_q != ST_IDLE;
  assign cur      = cur_q;
  assign irq      = irq_q;
  assign stat_cnt = scnt_q;
  assign stat_tc  = stc_q;
  assign stat_eos = seos_q;
endmodule

// File: rtl/txdma_chan.sv
module txdma_chan #(
  parameter int AW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_base,
  input  logic [CW-1:0] cfg_cnt,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [31:0]   rd_data,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  input  logic          tx_end,
  output logic          tx_tc,
  output logic          irq,
  output logic          nxt_buf,
  output logic [CW-1:0] stat_cnt,
  output logic          stat_tc,
  output logic          stat_eos
);
  logic          rst_meta, rst_sync;
  logic          d_vld, busy, cur, retire;
  logic [AW-1:0] d_base;
  logic [CW-1:0] d_cnt;
  logic          ld, adv, flush, u_one_left, u_empty;
  logic [1:0]    ld_first;
  logic [2:0]    ld_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  txdma_desc_bank #(.AW(AW), .CW(CW)) u_bank (
    .clk(clk), .rst_n(rst_sync), .wr(cfg_wr), .wr_sel(cfg_sel),
    .wr_base(cfg_base), .wr_cnt(cfg_cnt), .busy(busy), .cur(cur),
    .retire(retire), .base_o(d_base), .cnt_o(d_cnt), .vld_o(d_vld)
  );

  txdma_unpacker u_unp (
    .clk(clk), .rst_n(rst_sync), .ld(ld), .word_i(rd_data),
    .first_i(ld_first), .n_i(ld_n), .adv(adv), .flush(flush),
    .byte_o(tx_data), .one_left(u_one_left), .empty(u_empty)
  );

  txdma_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_sync), .d_vld(d_vld), .d_base(d_base),
    .d_cnt(d_cnt), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .ld(ld), .ld_first(ld_first), .ld_n(ld_n), .u_one_left(u_one_left),
    .adv(adv), .flush(flush), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_end(tx_end), .tx_tc(tx_tc), .busy(busy), .cur(cur),
    .retire(retire), .irq(irq), .stat_cnt(stat_cnt), .stat_tc(stat_tc),
    .stat_eos(stat_eos)
  );

  assign nxt_buf = cur;
endmodule

// File: rtl/txdma_chan_chk.sv
module txdma_chan_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ack,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          tx_end,
  input logic          tx_tc,
  input logic          irq,
  input logic          nxt_buf,
  input logic          stat_tc,
  input logic          stat_eos,
  input logic          u_empty
);
  // R2
  rd_idle_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && tx_valid));
  // R2
  unp_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !u_empty);
  // R3
  rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr[1:0] == 2'b00));
  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
  // R5
  tc_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_tc) |=> (irq && stat_tc));
  // R6
  eos_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_end) |=> (irq && stat_eos));
  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R7
  nxt_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (nxt_buf != $past(nxt_buf)));
  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !tx_valid);
endmodule

bind txdma_chan txdma_chan_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
  .rd_ack(rd_ack), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_end(tx_end), .tx_tc(tx_tc), .irq(irq), .nxt_buf(nxt_buf),
  .stat_tc(stat_tc), .stat_eos(stat_eos), .u_empty(u_empty)
);

// File: tb/sim_txdma_chan.sv
module sim_txdma_chan;
  localparam int CLK_P = 10;
  localparam int AW = 16;
  localparam int CW = 12;

  logic          clk, rst_n;
  logic          cfg_wr, cfg_sel;
  logic [AW-1:0] cfg_base;
  logic [CW-1:0] cfg_cnt;
  logic          rd_req, rd_ack;
  logic [AW-1:0] rd_addr;
  logic [31:0]   rd_data;
  logic          tx_valid, tx_ready, tx_end, tx_tc;
  logic [7:0]    tx_data;
  logic          irq, nxt_buf, stat_tc, stat_eos;
  logic [CW-1:0] stat_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  int exp_slot = 0;
  int nrun = 0;

  txdma_chan #(.AW(AW), .CW(CW)) u0 (.*);

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] mbyte(input int a);
    return 8'((a * 13 + 5) ^ (a >> 8));
  endfunction

  function automatic logic [31:0] mword(input int wa);
    return {mbyte(wa + 3), mbyte(wa + 2), mbyte(wa + 1), mbyte(wa)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic write_desc(input int slot, input int base, input int cnt);
    cfg_wr   = 1'b1;
    cfg_sel  = 1'(slot);
    cfg_base = AW'(base);
    cfg_cnt  = CW'(cnt);
  endtask

  // One buffer: endk < 0 means no peripheral end-of-stream
  task automatic run_buf(input int base, input int cnt, input int endk, input bit poke);
    int n_exp, rd_exp, k, reads, cyc;
    bit poked, ok_irq;
    n_exp  = (endk >= 0) ? endk + 1 : cnt;
    rd_exp = ((base + n_exp - 1) >> 2) - (base >> 2) + 1;
    k = 0; reads = 0; cyc = 0; poked = 0; ok_irq = 0;
    @(negedge clk);
    // R8: slot not loaded yet, peripheral held off
    chk(!tx_valid && !rd_req, "R8 hold-off", int'(tx_valid), 0);
    write_desc(exp_slot, base, cnt);
    forever begin
      @(negedge clk);
      cyc++;
      cfg_wr = 1'b0; tx_ready = 1'b0; tx_end = 1'b0; rd_ack = 1'b0;
      if (cyc > 200) begin
        chk(0, "R7 buffer end timeout", cyc, 200);
        break;
      end
      if (rd_req) begin
        // R3 / R10: aligned word at the current byte position
        chk(int'(rd_addr) == ((base + k) & ~3), "R3 read address", int'(rd_addr), (base + k) & ~3);
        reads++;
        rd_ack  = 1'b1;
        rd_data = mword(int'(rd_addr));
      end
      if (irq) begin
        ok_irq = 1;
        chk(k == n_exp, "R6 bytes accepted", k, n_exp);
        chk(int'(stat_cnt) == n_exp, "R6 stat_cnt", int'(stat_cnt), n_exp);
        chk(stat_tc == (n_exp == cnt), "R5 stat_tc", int'(stat_tc), int'(n_exp == cnt));
        chk(stat_eos == (endk >= 0), "R6 stat_eos", int'(stat_eos), int'(endk >= 0));
        chk(int'(nxt_buf) == 1 - exp_slot, "R7 nxt_buf", int'(nxt_buf), 1 - exp_slot);
        chk(reads == rd_exp, "R2 read count", reads, rd_exp);
        break;
      end
      if (tx_valid) begin
        // R4: memory order from base
        chk(tx_data == mbyte(base + k), "R4 byte value", int'(tx_data), int'(mbyte(base + k)));
        chk(tx_tc == (k == cnt - 1), "R5 tx_tc", int'(tx_tc), int'(k == cnt - 1));
        if (((cyc + k) % 3) != 2) begin
          tx_ready = 1'b1;
          tx_end   = (k == endk);
          k++;
        end
        if (poke && !poked && k >= 1) begin
          // R9: rewrite the slot in use; must not disturb this buffer
          write_desc(exp_slot, base + 64, cnt + 3);
          poked = 1;
        end
      end
    end
    @(negedge clk);
    cfg_wr = 1'b0; tx_ready = 1'b0; tx_end = 1'b0; rd_ack = 1'b0;
    if (ok_irq) chk(!irq, "R7 irq pulse width", int'(irq), 0);
    exp_slot = 1 - exp_slot;
    nrun++;
  endtask

  initial begin
    #(CLK_P * 150000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_base = '0; cfg_cnt = '0;
    rd_ack = 1'b0; rd_data = '0; tx_ready = 1'b0; tx_end = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(!rd_req && !tx_valid && !tx_tc && !irq, "R1 quiet outputs", int'(rd_req | tx_valid | irq), 0);
    chk(!nxt_buf && stat_cnt == '0 && !stat_tc && !stat_eos, "R1 status", int'(stat_cnt), 0);

    // R9: zero count leaves slot empty
    write_desc(0, 40, 0);
    @(negedge clk); cfg_wr = 1'b0;
    repeat (4) @(negedge clk);
    chk(!tx_valid && !rd_req, "R9 zero count ignored", int'(tx_valid | rd_req), 0);

    // R10: back-to-back buffers sharing a word
    run_buf(101, 2, -1, 0);
    run_buf(103, 3, -1, 0);

    for (int off = 0; off < 4; off++)
      for (int cnt = 1; cnt <= 9; cnt++)
        for (int e = -1; e < cnt; e++)
          run_buf(((nrun * 20) & 16'h3ff0) + off, cnt, e, (nrun % 5) == 0);

    finish_run();
  end
endmodule